// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Dual Select

This block holds instructions that are waiting for their operands and sends them on to two functional units. Each slot keeps two source tags, one ready flag for each, and the tag of the result it will produce. An instruction enters through a single dispatch port, one per cycle. The instruction is stored with the ready flags it arrived with, and any source that matches a tag being announced in that same cycle is stored as ready.

In every cycle the select stage looks at the slots whose two sources are both ready. It grants the oldest of them, by dispatch order, to functional unit 0 and the next oldest to functional unit 1. The result tags of the granted instructions are announced on the issue outputs and, in the same cycle, compared against every source tag held in the queue. Matching sources become ready at the clock edge, so a consumer can be granted in the cycle right after its producer. A granted slot is released at once. When no slot is free, dispatch is refused.

Top module: `iq_wakeup_select`

## Requirements
- R1: While reset is held, and in the first cycle after it, no issue output is valid and `disp_ready` is 1. Reset empties every slot.
- R2: An instruction dispatched with both sources ready, into a queue with no other requester, is issued on unit 0 in the cycle after dispatch, and its destination tag appears on `iss_dst[0]`.
- R3: A source that is not ready becomes ready at the clock edge that ends the cycle in which a granted instruction announces the same tag. The waiting instruction can be issued in the next cycle.
- R4: An instruction is never issued while either of its two source ready flags is clear.
- R5: At most two instructions issue per cycle. Unit 0 receives the requesting instruction dispatched earliest, and unit 1 receives the next earliest. The order comes from dispatch order, not from slot position. Whenever any slot requests, unit 0 is granted.
- R6: An instruction that has been issued leaves the queue and is never issued again.
- R7: A dispatched source whose tag equals a tag issued in the same cycle is stored as ready, so the instruction can issue in the following cycle.
- R8: `disp_ready` is 0 exactly when every slot is occupied. A dispatch offered while `disp_ready` is 0 is dropped: it never issues and it takes no slot.
- R9: `iss_vld[1]` is 1 only in a cycle in which `iss_vld[0]` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | 1 | A dispatch is offered this cycle |
| disp_ready | output | 1 | At least one slot is free, so the offered dispatch is accepted |
| disp_src_a_tag | input | TAG_W | First source tag |
| disp_src_a_rdy | input | 1 | First source already available |
| disp_src_b_tag | input | TAG_W | Second source tag |
| disp_src_b_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | TAG_W | Tag of the result this instruction produces |
| iss_vld | output | 2 | Per functional unit: an instruction is issued this cycle |
| iss_dst | output | 2 x TAG_W | Per functional unit: destination tag of the issued instruction, which is also the wakeup broadcast |

## Verification
The assertions rely on one property of the environment: the destination tags of the instructions in flight are unique. A tag is announced at most once, so a ready flag that is set can only come from its own producer. The bench gives every destination tag its own value and uses tag 0 only for sources that are marked ready at dispatch. It never reuses a destination tag until a reset has cleared the queue. It also offers a dispatch only after stepping past a clock edge, which keeps each dispatch to a single cycle. The exception is the one deliberate case where the bench holds `disp_vld` high on a full queue for several cycles.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int IQ_DEPTH = 8;
    localparam int TAG_W    = 7;
    localparam int NUM_FU   = 2;
    localparam int NUM_SRC  = 2;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic rdy;
        tag_t tag;
    } src_op_t;

    typedef struct packed {
        logic                     vld;
        src_op_t [NUM_SRC-1:0]    src;
        tag_t                     dst;
    } iq_slot_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } bcast_t;

    // True when any live broadcast carries tag t.
    function automatic logic tag_hit(input tag_t t, input bcast_t [NUM_FU-1:0] b);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < NUM_FU; p++) begin
            hit = hit | (b[p].vld & (b[p].tag == t));
        end
        return hit;
    endfunction

    // Apply wakeup to one source operand.
    function automatic src_op_t wake_src(input src_op_t s, input bcast_t [NUM_FU-1:0] b);
        src_op_t r;
        r     = s;
        r.rdy = s.rdy | tag_hit(s.tag, b);
        return r;
    endfunction
endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  iq_slot_t               wr_slot,
    input  bcast_t [NUM_FU-1:0]    bcast,
    input  logic                   grant,
    output iq_slot_t               slot,
    output logic                   req
);
    iq_slot_t slot_q;
    iq_slot_t slot_d;

    always_comb begin
        slot_d = slot_q;
        if (grant) begin
            slot_d.vld = 1'b0;
        end else if (wr_en) begin
            slot_d = wr_slot;
            for (int s = 0; s < NUM_SRC; s++) begin
                slot_d.src[s] = wake_src(wr_slot.src[s], bcast);
            end
        end else if (slot_q.vld) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                slot_d.src[s] = wake_src(slot_q.src[s], bcast);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign slot = slot_q;
    assign req  = slot_q.vld & slot_q.src[0].rdy & slot_q.src[1].rdy;

    // R6
    grant_frees_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> !slot_q.vld);

    // R4
    grant_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (slot_q.vld && slot_q.src[0].rdy && slot_q.src[1].rdy));

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !slot_q.vld);

    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_q.vld && !grant && slot_q.src[0].rdy && slot_q.src[1].rdy) |=> req);
endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             alloc,
    output logic [DEPTH-1:0][DEPTH-1:0]  older   // older[i][j]: slot i entered before slot j
);
    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc[j] && (i != j))
                        older_q[i][j] <= 1'b1;   // everyone predates the newcomer
                    else if (alloc[i])
                        older_q[i][j] <= 1'b0;   // newcomer predates nobody
                end
            end
        end
    end

    assign older = older_q;

    // R5
    alloc_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc));

    genvar gi, gj;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_row
            for (gj = gi + 1; gj < DEPTH; gj++) begin : g_col
                // R5
                age_antisym_chk: assert property (@(posedge clk) disable iff (rst)
                    !(older_q[gi][gj] && older_q[gj][gi]));
            end
        end
    endgenerate
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [DEPTH-1:0]                     req,
    input  logic [DEPTH-1:0][DEPTH-1:0]          older,
    output logic [iq_pkg::NUM_FU-1:0][DEPTH-1:0] gnt
);
    localparam int NFU = iq_pkg::NUM_FU;

    logic [DEPTH-1:0][DEPTH-1:0] older_t;   // older_t[i][j]: slot j entered before slot i
    logic [NFU:0][DEPTH-1:0]     pool;

    genvar gi, gj, gp;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_tr
            for (gj = 0; gj < DEPTH; gj++) begin : g_tc
                assign older_t[gi][gj] = older[gj][gi];
            end
        end

        assign pool[0] = req;
        for (gp = 0; gp < NFU; gp++) begin : g_port
            for (gi = 0; gi < DEPTH; gi++) begin : g_pick
                assign gnt[gp][gi] = pool[gp][gi] & ~(|(pool[gp] & older_t[gi]));
            end
            assign pool[gp+1] = pool[gp] & ~gnt[gp];

            // R5
            port_onehot_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(gnt[gp]));
        end
    endgenerate

    // R9
    port1_after_port0_chk: assert property (@(posedge clk) disable iff (rst)
        (|gnt[1]) |-> (|gnt[0]));

    // R6
    ports_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt[0] & gnt[1]) == '0);
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select
    import iq_pkg::*;
#(
    parameter int DEPTH = IQ_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          disp_vld,
    output logic                          disp_ready,
    input  logic [TAG_W-1:0]              disp_src_a_tag,
    input  logic                          disp_src_a_rdy,
    input  logic [TAG_W-1:0]              disp_src_b_tag,
    input  logic                          disp_src_b_rdy,
    input  logic [TAG_W-1:0]              disp_dst_tag,
    output logic [NUM_FU-1:0]             iss_vld,
    output logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst
);
    iq_slot_t [DEPTH-1:0]             slots;
    logic [DEPTH-1:0]                 req;
    logic [DEPTH-1:0]                 occ;
    logic [DEPTH-1:0]                 free_vec;
    logic [DEPTH-1:0]                 alloc;
    logic [DEPTH-1:0]                 slot_gnt;
    logic [DEPTH-1:0][DEPTH-1:0]      older;
    logic [NUM_FU-1:0][DEPTH-1:0]     gnt;
    bcast_t [NUM_FU-1:0]              bcast;
    iq_slot_t                         wr_slot;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) occ[i] = slots[i].vld;
    end

    assign free_vec   = ~occ;
    assign disp_ready = |free_vec;
    assign alloc      = (disp_vld && disp_ready) ? (free_vec & (~free_vec + 1'b1)) : '0;

    always_comb begin
        wr_slot            = '0;
        wr_slot.vld        = 1'b1;
        wr_slot.src[0].tag = disp_src_a_tag;
        wr_slot.src[0].rdy = disp_src_a_rdy;
        wr_slot.src[1].tag = disp_src_b_tag;
        wr_slot.src[1].rdy = disp_src_b_rdy;
        wr_slot.dst        = disp_dst_tag;
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            iq_entry u_entry (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (alloc[gi]),
                .wr_slot (wr_slot),
                .bcast   (bcast),
                .grant   (slot_gnt[gi]),
                .slot    (slots[gi]),
                .req     (req[gi])
            );
        end
    endgenerate

    iq_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk   (clk),
        .rst   (rst),
        .alloc (alloc),
        .older (older)
    );

    iq_select #(.DEPTH(DEPTH)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .older (older),
        .gnt   (gnt)
    );

    always_comb begin
        slot_gnt = '0;
        for (int p = 0; p < NUM_FU; p++) begin
            slot_gnt     = slot_gnt | gnt[p];
            bcast[p].vld = |gnt[p];
            bcast[p].tag = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (gnt[p][i]) bcast[p].tag = bcast[p].tag | slots[i].dst;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_FU; p++) begin
            iss_vld[p] = bcast[p].vld;
            iss_dst[p] = bcast[p].tag;
        end
    end

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(occ) == DEPTH) |-> !disp_ready);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_vld == '0 && disp_ready));

    // R5
    work_conserving_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> iss_vld[0]);

    // R5
    dual_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(req) >= 2) |-> (iss_vld == 2'b11));
endmodule

// File: tb/iq_wakeup_select_tb.sv
module iq_wakeup_select_tb;
    import iq_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                          rst;
    logic                          disp_vld;
    logic                          disp_ready;
    logic [TAG_W-1:0]              disp_src_a_tag;
    logic                          disp_src_a_rdy;
    logic [TAG_W-1:0]              disp_src_b_tag;
    logic                          disp_src_b_rdy;
    logic [TAG_W-1:0]              disp_dst_tag;
    logic [NUM_FU-1:0]             iss_vld;
    logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst;

    iq_wakeup_select u_dut (
        .clk            (clk),
        .rst            (rst),
        .disp_vld       (disp_vld),
        .disp_ready     (disp_ready),
        .disp_src_a_tag (disp_src_a_tag),
        .disp_src_a_rdy (disp_src_a_rdy),
        .disp_src_b_tag (disp_src_b_tag),
        .disp_src_b_rdy (disp_src_b_rdy),
        .disp_dst_tag   (disp_dst_tag),
        .iss_vld        (iss_vld),
        .iss_dst        (iss_dst)
    );

    typedef struct {
        int    cyc;
        int    port;
        int    tag;
        string req;
    } exp_t;

    exp_t sb[$];
    int   cyc    = 0;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", req, act, expv);
        end
    endtask

    task automatic push(input int c, input int p, input int t, input string r);
        exp_t e;
        e.cyc = c; e.port = p; e.tag = t; e.req = r;
        sb.push_back(e);
    endtask

    task automatic disp(input int sa, input bit ra, input int sb_t, input bit rb, input int d);
        disp_src_a_tag = TAG_W'(sa);
        disp_src_a_rdy = ra;
        disp_src_b_tag = TAG_W'(sb_t);
        disp_src_b_rdy = rb;
        disp_dst_tag   = TAG_W'(d);
        disp_vld       = 1'b1;
        @(posedge clk); #1;
        disp_vld       = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Monitor: compares every issue against the scoreboard queue.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !done) begin
            while (sb.size() > 0 && sb[0].cyc < cyc) begin
                e = sb.pop_front();
                check(1'b0, e.req, "no issue",
                      $sformatf("tag %0d port %0d cycle %0d", e.tag, e.port, e.cyc));
            end
            for (int p = 0; p < NUM_FU; p++) begin
                if (iss_vld[p]) begin
                    if (sb.size() == 0) begin
                        // R6 R8: nothing may issue that was not expected
                        check(1'b0, "R6", $sformatf("tag %0d port %0d cycle %0d", iss_dst[p], p, cyc),
                              "no issue");
                    end else begin
                        e = sb.pop_front();
                        check(e.cyc == cyc && e.port == p && e.tag == int'(iss_dst[p]), e.req,
                              $sformatf("tag %0d port %0d cycle %0d", iss_dst[p], p, cyc),
                              $sformatf("tag %0d port %0d cycle %0d", e.tag, e.port, e.cyc));
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        rst = 1'b1;
        disp_vld = 1'b0;
        disp_src_a_tag = '0; disp_src_a_rdy = 1'b0;
        disp_src_b_tag = '0; disp_src_b_rdy = 1'b0;
        disp_dst_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(disp_ready == 1'b1 && iss_vld == '0, "R1",
              $sformatf("ready %0b vld %b", disp_ready, iss_vld), "ready 1 vld 00");
        @(posedge clk); #1;
        rst = 1'b0;
        idle(1);

        // R2 single ready instruction
        k = cyc;
        push(k + 1, 0, 5, "R2");
        disp(0, 1, 0, 1, 5);
        idle(3);

        // R7 back-to-back chain through same-cycle wakeup at dispatch
        k = cyc;
        push(k + 1, 0, 10, "R2");
        push(k + 2, 0, 11, "R7");
        push(k + 3, 0, 12, "R7");
        disp(0, 1, 0, 1, 10);
        disp(10, 0, 0, 1, 11);
        disp(11, 0, 0, 1, 12);
        idle(3);

        // R3 R4 waiting instructions, woken later
        disp(20, 0, 0, 1, 21);
        disp(30, 0, 31, 0, 32);
        idle(3);
        k = cyc;
        push(k + 1, 0, 20, "R2");
        push(k + 2, 0, 21, "R3");
        push(k + 2, 1, 30, "R5");
        disp(0, 1, 0, 1, 20);
        disp(0, 1, 0, 1, 30);
        idle(3);   // R4: tag 32 must still wait for tag 31
        k = cyc;
        push(k + 1, 0, 31, "R2");
        push(k + 2, 0, 32, "R4");
        disp(0, 1, 0, 1, 31);
        idle(3);

        // R5 age order differs from slot order
        disp(60, 0, 0, 1, 61);   // slot 0
        disp(40, 0, 0, 1, 41);   // slot 1
        k = cyc;
        push(k + 1, 0, 60, "R2");
        push(k + 2, 0, 61, "R3");
        disp(0, 1, 0, 1, 60);    // slot 2
        idle(2);
        disp(40, 0, 0, 1, 42);   // slot 0, younger than 41
        disp(40, 0, 0, 1, 43);   // slot 2
        k = cyc;
        push(k + 1, 0, 40, "R2");
        push(k + 2, 0, 41, "R5");
        push(k + 2, 1, 42, "R5");
        push(k + 3, 0, 43, "R9");
        disp(0, 1, 0, 1, 40);
        idle(4);

        // R8 full queue refuses dispatch
        for (int i = 0; i < IQ_DEPTH; i++) disp(70, 0, 0, 1, 80 + i);
        @(negedge clk);
        check(disp_ready == 1'b0, "R8", $sformatf("ready %0b", disp_ready), "ready 0");
        @(posedge clk); #1;
        disp_src_a_tag = '0; disp_src_a_rdy = 1'b1;
        disp_src_b_tag = '0; disp_src_b_rdy = 1'b1;
        disp_dst_tag = TAG_W'(99);
        disp_vld = 1'b1;
        repeat (3) @(posedge clk);
        #1 disp_vld = 1'b0;
        @(negedge clk);
        check(disp_ready == 1'b0, "R8", $sformatf("ready %0b", disp_ready), "ready 0");

        // R1 reset empties the queue
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(disp_ready == 1'b1 && iss_vld == '0, "R1",
              $sformatf("ready %0b vld %b", disp_ready, iss_vld), "ready 1 vld 00");
        @(posedge clk); #1;
        rst = 1'b0;
        k = cyc;
        push(k + 1, 0, 7, "R1");
        disp(0, 1, 0, 1, 7);
        idle(3);

        check(sb.size() == 0, "R6", $sformatf("%0d pending", sb.size()), "0 pending");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule